// File: doc/BRIEF.md
# Select-bus serial channel controller

This block is one channel of a register-mapped controller for a serial peripheral bus on which each device has its own active-low select line. Software reaches it through five 32-bit registers on a simple write/read port. The registers are select, DMA address, DMA length, control and data. Software first picks one of the attached devices in the select register. It then writes the control register, which holds a start flag, a DMA flag, a direction code and a byte count. The block runs the transfer on a serial clock with one data-out and one data-in line. It clears the start flag when the transfer is finished, and software learns of completion by polling that flag.

An immediate transfer moves 1, 2 or 4 bytes. The bytes are left-justified in the data register and go out most significant bit first. A DMA read brings in a block of bytes whose size is a multiple of 32. It packs every four received bytes into one 32-bit word and writes each word to memory through a valid/ready write port. The write address starts at the DMA address register and goes up by 4 after each word.

The serial clock idles low. Each half period lasts `HALF_DIV` system clocks. The data-out line changes while the serial clock is low, and the data-in line is sampled on the rising edge.

Top module: `selbus_chan`

## Requirements
- R1: After reset, all five registers read zero, every `cs_n` line is high, `sclk` is low, `mosi` is high and `mem_valid` is low.
- R2: The select register (offset 0x00) holds a device field at bits 7+n, where bit 7+n drives `cs_n[n]` low. Writing zero to the field raises every select line, and all other bits of the register read zero.
- R3: The control register (offset 0x0C) has start at bit 0 and DMA at bit 1. Bits 3:2 hold the direction (0 = read, 1 = write) and bits 5:4 hold the byte count minus one (0 = 1 byte, 1 = 2, 3 = 4). These fields read back as written, and bits 31:6 read zero.
- R4: The start bit reads 1 for the whole transfer and clears by itself once the transfer ends. `sclk` is high only while start is set. Each serial bit takes `HALF_DIV` clocks with `sclk` low, then `HALF_DIV` clocks with `sclk` high.
- R5: Bits go out most significant bit first. `mosi` changes only while `sclk` is low, and `miso` is sampled on each rising edge of `sclk`.
- R6: An immediate write of n bytes sends data-register bits 31 down to 32-8n, and it leaves the data register (offset 0x10) unchanged.
- R7: An immediate read of n bytes holds `mosi` high. At the end it places the received bytes in data-register bits 31:32-8n, first byte highest, and clears the lower bits.
- R8: A write to the control register while start is set has no effect on any control field or on the running transfer.
- R9: A DMA read of L bytes issues L/4 memory writes. Word i goes to address base+4i and carries received byte 4i in bits 31:24, down to byte 4i+3 in bits 7:0. Address and data hold steady while `mem_valid` waits for `mem_ready`, and start clears only after the last word is accepted.
- R10: The DMA address register (0x04) and the DMA length register (0x08) ignore bits 4:0, which read zero. The length register also reads zero above the count width (bit 15 by default).
- R11: A start request with the DMA bit set and a non-zero direction stores the fields but leaves start clear. It produces no serial clock and no memory write.
- R12: A DMA read whose length register is zero sets start for one cycle and then clears it, with no serial clock and no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for the register at `bus_addr` (combinational) |
| cs_n | output | NUM_DEV | Active-low device selects |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 32 | Memory write byte address |
| mem_wdata | output | 32 | Memory write data word |

## Verification
The select-line property assumes that software never sets more than one bit of the device field, so the bench only writes zero or a single device bit there. The memory-port property assumes that `mem_ready` may be withheld for any number of cycles. The bench drives a repeating stall pattern during DMA to exercise that case. The mosi-timing and busy-write properties assume that register writes come from the bus port only. The bench issues every write as a one-cycle strobe and sends control writes while a transfer is running. A device model in the bench drives `miso` from a byte table and records `mosi` on each rising `sclk`, so transmitted and received bytes are compared against values worked out from the requirements.

// File: rtl/selbus_pkg.sv
package selbus_pkg;

    localparam logic [4:0] OFS_SEL   = 5'h00;
    localparam logic [4:0] OFS_DADDR = 5'h04;
    localparam logic [4:0] OFS_DLEN  = 5'h08;
    localparam logic [4:0] OFS_CTRL  = 5'h0C;
    localparam logic [4:0] OFS_DATA  = 5'h10;

    localparam int CS_LSB    = 7;
    localparam int ALIGN_LSB = 5;

    localparam logic [1:0] DIR_RD = 2'd0;
    localparam logic [1:0] DIR_WR = 2'd1;

    typedef struct packed {
        logic [1:0] len_m1;
        logic [1:0] dir;
        logic       dma;
        logic       start;
    } ctrl_t;

    // Place the newest len_m1+1 bytes of a shift history at the top of a word.
    function automatic logic [31:0] left_just(input logic [31:0] w, input logic [1:0] len_m1);
        case (len_m1)
            2'd0:    return {w[7:0], 24'h0};
            2'd1:    return {w[15:0], 16'h0};
            2'd2:    return {w[23:0], 8'h0};
            default: return w;
        endcase
    endfunction

endpackage

// File: rtl/selbus_shifter.sv
module selbus_shifter #(
    parameter int HALF_DIV = 2,
    parameter int CNT_W    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [CNT_W-1:0] nbytes,
    input  logic [31:0]      tx_word,
    input  logic             tx_en,
    input  logic             hold,
    input  logic             miso,
    output logic             sclk,
    output logic             mosi,
    output logic             busy,
    output logic             byte_ev,
    output logic [7:0]       byte_rx,
    output logic             last_ev
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_END = DIV_W'(HALF_DIV - 1);

    logic [DIV_W-1:0] div_q;
    logic [2:0]       bit_q;
    logic [CNT_W-1:0] left_q;
    logic [31:0]      txsr_q;
    logic [7:0]       rxsr_q;
    logic             sclk_q, busy_q;
    logic             half_end, advance, fall_ev;

    assign half_end = (div_q == DIV_END);
    assign advance  = busy_q && !(hold && !sclk_q);
    assign fall_ev  = advance && half_end && sclk_q;
    assign byte_ev  = fall_ev && (bit_q == 3'd7);
    assign last_ev  = byte_ev && (left_q == CNT_W'(1));
    assign byte_rx  = rxsr_q;
    assign sclk     = sclk_q;
    assign busy     = busy_q;
    assign mosi     = (busy_q && tx_en) ? txsr_q[31] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            bit_q  <= '0;
            left_q <= '0;
            txsr_q <= '0;
            rxsr_q <= '0;
            sclk_q <= 1'b0;
            busy_q <= 1'b0;
        end else if (!busy_q) begin
            if (go && (nbytes != '0)) begin
                busy_q <= 1'b1;
                left_q <= nbytes;
                txsr_q <= tx_word;
                div_q  <= '0;
                bit_q  <= '0;
                sclk_q <= 1'b0;
            end
        end else if (advance) begin
            if (!half_end) begin
                div_q <= div_q + 1'b1;
            end else begin
                div_q <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    rxsr_q <= {rxsr_q[6:0], miso};
                end else begin
                    sclk_q <= 1'b0;
                    txsr_q <= {txsr_q[30:0], 1'b0};
                    bit_q  <= bit_q + 1'b1;
                    if (bit_q == 3'd7) begin
                        left_q <= left_q - 1'b1;
                        if (left_q == CNT_W'(1))
                            busy_q <= 1'b0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/selbus_dma_wr.sv
module selbus_dma_wr (
    input  logic        clk,
    input  logic        rst,
    input  logic        go,
    input  logic [31:0] base,
    input  logic        byte_ev,
    input  logic [7:0]  byte_rx,
    input  logic        mem_ready,
    output logic        mem_valid,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata
);
    logic [23:0] pack_q;
    logic [1:0]  cnt_q;
    logic [31:0] addr_q, word_q;
    logic        valid_q;

    assign mem_valid = valid_q;
    assign mem_addr  = addr_q;
    assign mem_wdata = word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pack_q  <= '0;
            cnt_q   <= '0;
            addr_q  <= '0;
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            if (go) begin
                addr_q <= base;
                cnt_q  <= '0;
            end else if (valid_q && mem_ready) begin
                valid_q <= 1'b0;
                addr_q  <= addr_q + 32'd4;
            end
            if (byte_ev) begin
                if (cnt_q == 2'd3) begin
                    word_q  <= {pack_q, byte_rx};
                    valid_q <= 1'b1;
                    cnt_q   <= '0;
                end else begin
                    pack_q <= {pack_q[15:0], byte_rx};
                    cnt_q  <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/selbus_chan.sv
module selbus_chan
    import selbus_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int NUM_DEV  = 3,
    parameter int CNT_W    = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic [4:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_DEV-1:0] cs_n,
    output logic               sclk,
    output logic               mosi,
    input  logic               miso,
    output logic               mem_valid,
    input  logic               mem_ready,
    output logic [31:0]        mem_addr,
    output logic [31:0]        mem_wdata
);
    logic [NUM_DEV-1:0]       sel_q;
    logic [31:ALIGN_LSB]      daddr_q;
    logic [CNT_W-1:ALIGN_LSB] dlen_q;
    ctrl_t                    ctrl_q, req;
    logic [31:0]              data_q;
    logic [23:0]              acc_q;
    logic [31:0]              nxt_acc;

    logic wr_sel, wr_daddr, wr_dlen, wr_ctrl, wr_data;
    logic go, dma_go, tx_en;
    logic [CNT_W-1:0] nbytes;
    logic sh_busy, sh_byte, sh_last;
    logic [7:0] sh_rx;
    logic run_w;
    logic [4:0] fld_w;

    assign wr_sel   = bus_wr && (bus_addr == OFS_SEL);
    assign wr_daddr = bus_wr && (bus_addr == OFS_DADDR);
    assign wr_dlen  = bus_wr && (bus_addr == OFS_DLEN);
    assign wr_ctrl  = bus_wr && (bus_addr == OFS_CTRL);
    assign wr_data  = bus_wr && (bus_addr == OFS_DATA);

    assign req    = ctrl_t'(bus_wdata[5:0]);
    assign go     = wr_ctrl && !ctrl_q.start && req.start && !(req.dma && (req.dir != DIR_RD));
    assign dma_go = go && req.dma;
    assign nbytes = req.dma ? {dlen_q, {ALIGN_LSB{1'b0}}}
                            : CNT_W'(req.len_m1) + CNT_W'(1);
    assign tx_en  = (ctrl_q.dir == DIR_WR) && !ctrl_q.dma;
    assign nxt_acc = {acc_q, sh_rx};
    assign cs_n   = ~sel_q;
    assign run_w  = ctrl_q.start;
    assign fld_w  = ctrl_q[5:1];

    selbus_shifter #(.HALF_DIV(HALF_DIV), .CNT_W(CNT_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .nbytes  (nbytes),
        .tx_word (data_q),
        .tx_en   (tx_en),
        .hold    (mem_valid),
        .miso    (miso),
        .sclk    (sclk),
        .mosi    (mosi),
        .busy    (sh_busy),
        .byte_ev (sh_byte),
        .byte_rx (sh_rx),
        .last_ev (sh_last)
    );

    selbus_dma_wr u_dma (
        .clk       (clk),
        .rst       (rst),
        .go        (dma_go),
        .base      ({daddr_q, {ALIGN_LSB{1'b0}}}),
        .byte_ev   (sh_byte && ctrl_q.dma),
        .byte_rx   (sh_rx),
        .mem_ready (mem_ready),
        .mem_valid (mem_valid),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= '0;
            daddr_q <= '0;
            dlen_q  <= '0;
            ctrl_q  <= '0;
            data_q  <= '0;
            acc_q   <= '0;
        end else begin
            if (wr_sel)   sel_q   <= bus_wdata[CS_LSB +: NUM_DEV];
            if (wr_daddr) daddr_q <= bus_wdata[31:ALIGN_LSB];
            if (wr_dlen)  dlen_q  <= bus_wdata[CNT_W-1:ALIGN_LSB];
            if (wr_data)  data_q  <= bus_wdata;

            if (ctrl_q.start) begin
                if (!sh_busy && !mem_valid)
                    ctrl_q.start <= 1'b0;
            end else if (wr_ctrl) begin
                ctrl_q.len_m1 <= req.len_m1;
                ctrl_q.dir    <= req.dir;
                ctrl_q.dma    <= req.dma;
                ctrl_q.start  <= go;
            end

            if (sh_byte && !ctrl_q.dma)
                acc_q <= nxt_acc[23:0];
            if (sh_last && !ctrl_q.dma && (ctrl_q.dir == DIR_RD))
                data_q <= left_just(nxt_acc, ctrl_q.len_m1);
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_SEL:   bus_rdata = 32'(sel_q) << CS_LSB;
            OFS_DADDR: bus_rdata = {daddr_q, {ALIGN_LSB{1'b0}}};
            OFS_DLEN:  bus_rdata = 32'({dlen_q, {ALIGN_LSB{1'b0}}});
            OFS_CTRL:  bus_rdata = {26'h0, ctrl_q};
            OFS_DATA:  bus_rdata = data_q;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/selbus_chan_chk.sv
module selbus_chan_chk #(
    parameter int NUM_DEV = 3
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_DEV-1:0] cs_n,
    input logic               sclk,
    input logic               mosi,
    input logic               mem_valid,
    input logic               mem_ready,
    input logic [31:0]        mem_addr,
    input logic [31:0]        mem_wdata,
    input logic               run,
    input logic [4:0]         fld,
    input logic               bus_wr,
    input logic [4:0]         bus_addr
);
    // R2
    cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    // R4
    sclk_run_chk: assert property (@(posedge clk) disable iff (rst)
        sclk |-> run);

    // R5
    mosi_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(mosi) |-> !sclk);

    // R8
    busy_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
        (run && bus_wr && (bus_addr == 5'h0C)) |=> $stable(fld));

    // R9
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_wdata)));

    // R9
    mem_run_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> run);
endmodule

bind selbus_chan selbus_chan_chk #(.NUM_DEV(NUM_DEV)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .mosi      (mosi),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .run       (run_w),
    .fld       (fld_w),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr)
);

// File: tb/selbus_chan_bench.sv
module selbus_chan_bench;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [4:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [2:0]  cs_n;
    logic        sclk, mosi, miso_r;
    logic        mem_valid, mem_ready, mem_addr_unused;
    logic [31:0] mem_addr, mem_wdata;

    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    selbus_chan #(.HALF_DIV(HALF)) u_selbus_chan (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cs_n(cs_n),
        .sclk(sclk), .mosi(mosi), .miso(miso_r), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );
    assign mem_addr_unused = 1'b0;

    // Device model: byte table on miso, capture of mosi.
    logic [7:0] dev_tx [0:255];
    logic [7:0] got_q [$];
    logic [7:0] cur;
    int gidx = 0;
    int bitc = 0;
    int rises = 0;
    int hi_cnt = 0;

    always @(posedge sclk) begin
        cur = {cur[6:0], mosi};
        bitc++;
        rises++;
        if (bitc == 8) begin
            got_q.push_back(cur);
            bitc = 0;
        end
    end

    always @(negedge sclk) begin
        gidx++;
        miso_r = dev_tx[8'(gidx / 8)][3'(7 - (gidx % 8))];
    end

    task automatic dev_reset();
        gidx = 0;
        bitc = 0;
        rises = 0;
        hi_cnt = 0;
        got_q.delete();
        miso_r = dev_tx[0][7];
    endtask

    // Memory model with optional stalls.
    logic [31:0] wa_q [$];
    logic [31:0] wd_q [$];
    logic stall_en = 1'b0;
    int rc = 0;

    always @(posedge clk)
        if (!rst && mem_valid && mem_ready) begin
            wa_q.push_back(mem_addr);
            wd_q.push_back(mem_wdata);
        end

    always @(negedge clk) begin
        rc++;
        mem_ready = !stall_en || (rc % 3 != 0);
    end

    // Per-clock reference of the select lines.
    logic [2:0] exp_cs = 3'b000;

    always @(negedge clk)
        if (!rst) begin
            if (sclk) hi_cnt++;
            checks++;
            if (cs_n !== ~exp_cs) begin
                fails++;
                $display("FAIL R2 cs_n actual=%b expected=%b", cs_n, ~exp_cs);
            end
        end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(posedge clk);
        #1;
        if (a == 5'h00) exp_cs = d[9:7];
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_done();
        logic [31:0] v;
        v = 32'h1;
        for (int i = 0; i < 40000 && v[0]; i++) rd(5'h0C, v);
    endtask

    task automatic imm_write(input logic [5:0] code, input int n, input logic [31:0] word);
        logic [31:0] v;
        wr(5'h10, word);
        dev_reset();
        wr(5'h0C, {26'h0, code});
        rd(5'h0C, v);
        chk("R4 start set while running", v, {26'h0, code});
        wait_done();
        chk("R4 sclk rises", rises, 8 * n);
        chk("R5 byte count", got_q.size(), n);
        for (int k = 0; k < n && k < got_q.size(); k++)
            chk("R5/R6 sent byte", {24'h0, got_q[k]}, {24'h0, word[31 - 8 * k -: 8]});
        rd(5'h10, v);
        chk("R6 data unchanged", v, word);
    endtask

    task automatic imm_read(input logic [5:0] code, input int n, input logic [31:0] exp);
        logic [31:0] v;
        dev_reset();
        wr(5'h0C, {26'h0, code});
        wait_done();
        rd(5'h10, v);
        chk("R7 data left-justified", v, exp);
        for (int k = 0; k < n && k < got_q.size(); k++)
            chk("R7 mosi high", {24'h0, got_q[k]}, 32'hFF);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 256; i++) dev_tx[i] = 8'hFF;
        rst = 1'b1;
        bus_wr = 1'b0;
        bus_addr = 5'h0;
        bus_wdata = 32'h0;
        miso_r = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(5'(a * 4), v);
            chk("R1 register reset", v, 32'h0);
        end
        chk("R1 cs_n", {29'h0, cs_n}, 32'h7);
        chk("R1 sclk/mosi/mem_valid", {29'h0, sclk, mosi, mem_valid}, 32'h2);

        // R2 select
        wr(5'h00, 32'h100);
        rd(5'h00, v);
        chk("R2 select readback", v, 32'h100);
        chk("R2 cs_n dev1", {29'h0, cs_n}, 32'h5);
        wr(5'h00, 32'h0);
        chk("R2 deselect", {29'h0, cs_n}, 32'h7);
        wr(5'h00, 32'h80);
        rd(5'h00, v);
        chk("R2 other bits zero", v, 32'h80);

        // Immediate writes: R3 R4 R5 R6
        imm_write(6'h05, 1, 32'hA5C3_1234);
        chk("R4 sclk high cycles", hi_cnt, 8 * HALF);
        imm_write(6'h15, 2, 32'h5A3C_0F81);
        imm_write(6'h35, 4, 32'h9E21_C4B7);
        rd(5'h0C, v);
        chk("R3 control readback", v, 32'h34);

        // Immediate reads: R7
        dev_tx[0] = 8'h3C; dev_tx[1] = 8'h96; dev_tx[2] = 8'hE1; dev_tx[3] = 8'h7F;
        wr(5'h10, 32'hFFFF_FFFF);
        imm_read(6'h01, 1, 32'h3C00_0000);
        imm_read(6'h11, 2, 32'h3C96_0000);
        imm_read(6'h31, 4, 32'h3C96_E17F);

        // R8 control write during transfer ignored
        wr(5'h10, 32'hC001_D00D);
        dev_reset();
        wr(5'h0C, 32'h35);
        wr(5'h0C, 32'h01);
        rd(5'h0C, v);
        chk("R8 fields kept", v, 32'h35);
        wait_done();
        chk("R8 transfer length kept", rises, 32);
        chk("R8 last byte", {24'h0, got_q[3]}, 32'h0D);
        rd(5'h0C, v);
        chk("R8 control after done", v, 32'h34);

        // R10 alignment of DMA registers
        wr(5'h04, 32'h0000_2013);
        rd(5'h04, v);
        chk("R10 address low bits", v, 32'h0000_2000);
        wr(5'h08, 32'hFFFF_004F);
        rd(5'h08, v);
        chk("R10 length bits", v, 32'h0000_0040);

        // R9 DMA read of 64 bytes with stalls
        for (int i = 0; i < 256; i++) dev_tx[i] = 8'(i * 7 + 3);
        stall_en = 1'b1;
        wa_q.delete();
        wd_q.delete();
        dev_reset();
        wr(5'h0C, 32'h03);
        wait_done();
        chk("R9 word count", wa_q.size(), 16);
        for (int i = 0; i < 16 && i < wa_q.size(); i++) begin
            chk("R9 address", wa_q[i], 32'h2000 + 32'(4 * i));
            chk("R9 data", wd_q[i], {8'(4*i*7+3), 8'((4*i+1)*7+3), 8'((4*i+2)*7+3), 8'((4*i+3)*7+3)});
        end
        chk("R9 idle after done", {31'h0, mem_valid}, 32'h0);

        // R9 DMA of 32 bytes without stalls at a new base
        stall_en = 1'b0;
        wa_q.delete();
        wd_q.delete();
        wr(5'h04, 32'h0000_0840);
        wr(5'h08, 32'h20);
        dev_reset();
        wr(5'h0C, 32'h03);
        wait_done();
        chk("R9 word count 32B", wa_q.size(), 8);
        if (wa_q.size() == 8) begin
            chk("R9 last address", wa_q[7], 32'h085C);
            chk("R9 last data", wd_q[7], {8'(28*7+3), 8'(29*7+3), 8'(30*7+3), 8'(31*7+3)});
        end

        // R11 DMA with write direction refused
        wa_q.delete();
        dev_reset();
        wr(5'h0C, 32'h07);
        rd(5'h0C, v);
        chk("R11 start stays clear", v, 32'h06);
        repeat (40) @(negedge clk);
        chk("R11 no serial clock", rises, 0);
        chk("R11 no memory write", wa_q.size(), 0);

        // R12 zero-length DMA
        wr(5'h08, 32'h0);
        dev_reset();
        wr(5'h0C, 32'h03);
        wait_done();
        repeat (10) @(negedge clk);
        rd(5'h0C, v);
        chk("R12 control after done", v, 32'h02);
        chk("R12 no serial clock", rises, 0);
        chk("R12 no memory write", wa_q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule